// File: doc/BRIEF.md
# Quadrature CW Tone Generator

This block produces a continuous-wave test tone as two sample streams, in-phase and quadrature, for a direct-conversion transmitter. The transmit interface clock runs at twice the sample rate. An internal divide-by-two enable advances a 32-bit phase accumulator by a programmable tuning word once per sample, so the tone frequency is `tune_word / 2^32` of the sample rate. The top phase bits address a quarter-wave sine table, which is folded by symmetry to cover the full cycle. The I path carries the cosine of the phase and the Q path carries the sine.

A host writes a linear back-off factor that scales both paths. It also writes a gain factor and a phase addend that pre-correct static IQ imbalance on the Q path only. A direction bit mirrors the Q path so the tone can be placed on either side of the carrier. Each output pair is a 12-bit offset-binary code with mid-scale at 2048, and a one-cycle strobe marks it. The host converts any dB figures to linear form before writing them.

Top module: `qtone_gen`

## Requirements
- R1: While `rst` is high, and after it is released until the first strobe, `samp_valid` is 0 and both sample outputs hold 2048. The accumulator restarts at 0, so the first pair after reset uses phase 0.
- R2: After reset, `samp_valid` pulses high for one clock every second clock and is never high on two consecutive clocks.
- R3: Pair number k (counting from 0 after reset) uses phase word θ = bits [31:22] of (k · `tune_word`) mod 2^32.
- R4: The I path uses the signed table value S(θ + 256 mod 1024), the cosine. S(a) = round(2047 · sin(2π(a + 0.5)/1024)).
- R5: The Q path uses S(θ + `q_phase_ofs` mod 1024), the sine advanced by the 10-bit phase addend.
- R6: With `rot_neg` = 1, the sign of the Q value is inverted. The I path is unaffected.
- R7: Both paths are scaled in magnitude: m = floor(|S| · `backoff` / 32768). `backoff` is unsigned with 15 fraction bits, so 32768 is 1.0 and 0 gives silence.
- R8: The Q magnitude is scaled again after back-off: floor(m · `q_gain` / 32768). The I path does not see `q_gain`.
- R9: Each output code is 2048 + m for positive values and 2048 − m for negative values, saturated to the range 0 to 4095.
- R10: The table is symmetric. Phases a and a + 512 give values of equal magnitude and opposite sign, and S(0) = +6.
- R11: The sample outputs change only on clocks where `samp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit interface clock, twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| tune_word | input | 32 | Phase increment per sample |
| backoff | input | 16 | Amplitude scale for both paths, unsigned with 15 fraction bits |
| q_gain | input | 16 | Q-path gain correction, unsigned with 15 fraction bits |
| q_phase_ofs | input | 10 | Phase addend for the Q path, in 1/1024 cycle |
| rot_neg | input | 1 | 1 inverts the Q sign (opposite rotation) |
| i_samp | output | 12 | In-phase sample, offset binary |
| q_samp | output | 12 | Quadrature sample, offset binary |
| samp_valid | output | 1 | One-clock strobe marking a new pair |

## Verification
The bench builds the generator with its default parameters: a 32-bit accumulator, a 10-bit table phase, 12-bit outputs and 16-bit coefficients with 15 fraction bits. At this size a tuning word of 0 freezes the phase on a single table point, so the exact codes at the peaks and at the symmetric points can be predicted. Coefficients of 0xFFFF drive both paths hard into the 0 and 4095 rails. The vector walk covers low, irregular, near-Nyquist and negative tuning words over 24 pairs each. This exercises every quadrant fold, every phase addend wrap and both rotation senses.

// File: rtl/qtone_pkg.sv
package qtone_pkg;

    localparam int ACC_W     = 32;
    localparam int PH_W      = 10;
    localparam int OUT_W     = 12;
    localparam int COEF_FRAC = 15;
    localparam int COEF_W    = COEF_FRAC + 1;

    localparam int QTR_W   = PH_W - 2;
    localparam int QTR_N   = 1 << QTR_W;
    localparam int MAG_W   = OUT_W - 1;
    localparam int MAG_MAX = (1 << MAG_W) - 1;
    localparam int MID     = 1 << (OUT_W - 1);
    localparam int OUT_MAX = (1 << OUT_W) - 1;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } tone_samp_t;

    typedef struct packed {
        logic             neg;
        logic [MAG_W:0]   mag;
    } tone_wide_t;

    // sin((2j+1)*pi / 2^ph_w) * amp, rounded, via Q30 Taylor series
    function automatic longint qtr_sine(input int j, input int ph_w, input int amp);
        longint pi_q30;
        longint x;
        longint x2;
        longint term;
        longint acc;
        pi_q30 = 64'd3373259426;
        x      = (longint'(2 * j + 1) * pi_q30) >>> ph_w;
        x2     = (x * x) >>> 30;
        term   = x;
        acc    = x;
        for (int n = 1; n <= 6; n++) begin
            term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return (acc * longint'(amp) + (longint'(1) <<< 29)) >>> 30;
    endfunction

    function automatic logic [OUT_W-1:0] to_offset(input logic neg,
                                                   input logic [MAG_W+1:0] m);
        int v;
        v = neg ? (MID - int'(m)) : (MID + int'(m));
        if (v < 0)       v = 0;
        if (v > OUT_MAX) v = OUT_MAX;
        return OUT_W'(v);
    endfunction

endpackage

// File: rtl/qtone_phase.sv
module qtone_phase #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] tune,
    output logic [PH_W-1:0]  ph_out,
    output logic             ph_vld
);

    logic             en_q;
    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            acc    <= '0;
            ph_out <= '0;
            ph_vld <= 1'b0;
        end else begin
            en_q   <= ~en_q;
            ph_vld <= en_q;
            if (en_q) begin
                ph_out <= acc[ACC_W-1 -: PH_W];
                acc    <= acc + tune;
            end
        end
    end

    // R3
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        en_q |=> (acc == $past(acc) + $past(tune)));

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> $stable(acc));

endmodule

// File: rtl/qtone_qrom.sv
module qtone_qrom
    import qtone_pkg::*;
#(
    parameter int PH_W   = 10,
    parameter int N_PORT = 2
) (
    input  logic [N_PORT-1:0][PH_W-1:0] ph,
    output tone_samp_t [N_PORT-1:0]     smp
);

    localparam int QW = PH_W - 2;
    localparam int QN = 1 << QW;

    logic [MAG_W-1:0] tbl [QN];

    for (genvar gi = 0; gi < QN; gi++) begin : g_tbl
        assign tbl[gi] = MAG_W'(qtr_sine(gi, PH_W, MAG_MAX));
    end

    for (genvar gp = 0; gp < N_PORT; gp++) begin : g_port
        logic [1:0]    quad;
        logic [QW-1:0] idx;
        assign quad = ph[gp][PH_W-1 -: 2];
        assign idx  = quad[0] ? ~ph[gp][QW-1:0] : ph[gp][QW-1:0];
        assign smp[gp].neg = quad[1];
        assign smp[gp].mag = tbl[idx];
    end

endmodule

// File: rtl/qtone_scale.sv
module qtone_scale #(
    parameter int IN_W   = 11,
    parameter int COEF_W = 16,
    parameter int FRAC   = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic              in_neg,
    input  logic [IN_W-1:0]   in_mag,
    input  logic [COEF_W-1:0] coef,
    output logic              out_vld,
    output logic              out_neg,
    output logic [IN_W:0]     out_mag
);

    localparam int PROD_W = IN_W + COEF_W;
    localparam logic [COEF_W-1:0] ONE = COEF_W'(1 << FRAC);

    logic [PROD_W-1:0] prod;

    assign prod = PROD_W'(in_mag) * PROD_W'(coef);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_neg <= 1'b0;
            out_mag <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_neg <= in_neg;
                out_mag <= (IN_W + 1)'(prod >> FRAC);
            end
        end
    end

    // R7
    no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && coef <= ONE) |=> (out_mag <= (IN_W + 1)'($past(in_mag))));

    // R7
    zero_coef_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && coef == '0) |=> (out_mag == '0));

endmodule

// File: rtl/qtone_gen.sv
module qtone_gen
    import qtone_pkg::*;
#(
    parameter int ACC_BITS  = qtone_pkg::ACC_W,
    parameter int PH_BITS   = qtone_pkg::PH_W,
    parameter int OUT_BITS  = qtone_pkg::OUT_W,
    parameter int COEF_BITS = qtone_pkg::COEF_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ACC_BITS-1:0]  tune_word,
    input  logic [COEF_BITS-1:0] backoff,
    input  logic [COEF_BITS-1:0] q_gain,
    input  logic [PH_BITS-1:0]   q_phase_ofs,
    input  logic                 rot_neg,
    output logic [OUT_BITS-1:0]  i_samp,
    output logic [OUT_BITS-1:0]  q_samp,
    output logic                 samp_valid
);

    localparam logic [PH_BITS-1:0] QUARTER = PH_BITS'(1 << (PH_BITS - 2));

    // phase generation
    logic [PH_BITS-1:0] ph_top;
    logic               ph_vld;

    qtone_phase #(.ACC_W(ACC_BITS), .PH_W(PH_BITS)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .tune   (tune_word),
        .ph_out (ph_top),
        .ph_vld (ph_vld)
    );

    // table lookup: port 0 cosine for I, port 1 offset sine for Q
    logic [1:0][PH_BITS-1:0] rd_ph;
    tone_samp_t [1:0]        rd_smp;

    assign rd_ph[0] = ph_top + QUARTER;
    assign rd_ph[1] = ph_top + q_phase_ofs;

    qtone_qrom #(.PH_W(PH_BITS), .N_PORT(2)) u_rom (
        .ph  (rd_ph),
        .smp (rd_smp)
    );

    tone_samp_t lk_i;
    tone_samp_t lk_q;
    logic       lk_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_vld <= 1'b0;
            lk_i   <= '0;
            lk_q   <= '0;
        end else begin
            lk_vld <= ph_vld;
            if (ph_vld) begin
                lk_i     <= rd_smp[0];
                lk_q.neg <= rd_smp[1].neg ^ rot_neg;
                lk_q.mag <= rd_smp[1].mag;
            end
        end
    end

    // back-off on both paths
    tone_wide_t bi;
    tone_wide_t bq;
    logic       bi_vld;
    logic       bq_vld;

    qtone_scale #(.IN_W(MAG_W), .COEF_W(COEF_BITS), .FRAC(COEF_FRAC)) u_bo_i (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (lk_vld),
        .in_neg  (lk_i.neg),
        .in_mag  (lk_i.mag),
        .coef    (backoff),
        .out_vld (bi_vld),
        .out_neg (bi.neg),
        .out_mag (bi.mag)
    );

    qtone_scale #(.IN_W(MAG_W), .COEF_W(COEF_BITS), .FRAC(COEF_FRAC)) u_bo_q (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (lk_vld),
        .in_neg  (lk_q.neg),
        .in_mag  (lk_q.mag),
        .coef    (backoff),
        .out_vld (bq_vld),
        .out_neg (bq.neg),
        .out_mag (bq.mag)
    );

    // Q gain correction, I delayed to match
    logic             gq_vld;
    logic             gq_neg;
    logic [MAG_W+1:0] gq_mag;
    tone_wide_t       id;

    qtone_scale #(.IN_W(MAG_W + 1), .COEF_W(COEF_BITS), .FRAC(COEF_FRAC)) u_gn_q (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (bq_vld),
        .in_neg  (bq.neg),
        .in_mag  (bq.mag),
        .coef    (q_gain),
        .out_vld (gq_vld),
        .out_neg (gq_neg),
        .out_mag (gq_mag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            id <= '0;
        end else if (bi_vld) begin
            id <= bi;
        end
    end

    // offset-binary mapping with saturation
    always_ff @(posedge clk) begin
        if (rst) begin
            i_samp     <= OUT_BITS'(MID);
            q_samp     <= OUT_BITS'(MID);
            samp_valid <= 1'b0;
        end else begin
            samp_valid <= gq_vld;
            if (gq_vld) begin
                i_samp <= to_offset(id.neg, {1'b0, id.mag});
                q_samp <= to_offset(gq_neg, gq_mag);
            end
        end
    end

    // R2
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        samp_valid |=> !samp_valid);

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({i_samp, q_samp}) |-> samp_valid);

    // R6
    dir_sign_chk: assert property (@(posedge clk) disable iff (rst)
        ph_vld |=> (lk_q.neg == ($past(rd_smp[1].neg) ^ $past(rot_neg))));

endmodule

// File: tb/test_qtone_gen.sv
module test_qtone_gen;
    import qtone_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 24;
    localparam int NV         = 7;
    localparam int TOL        = 2;
    localparam int WDOG       = 150000;

    // {tune, backoff, gain, ofs, dir}
    localparam logic [74:0] VECS [NV] = '{
        {32'h0100_0000, 16'd32768, 16'd32768, 10'd0,    1'b0},
        {32'h1234_5678, 16'd16384, 16'd32768, 10'd0,    1'b0},
        {32'h0400_0000, 16'd32768, 16'd32768, 10'd0,    1'b1},
        {32'h0AAA_AAAB, 16'd24576, 16'd36000, 10'd0,    1'b0},
        {32'h0123_4567, 16'd32768, 16'd29000, 10'd17,   1'b0},
        {32'hF000_0000, 16'd20000, 16'd32768, 10'd1000, 1'b1},
        {32'h7FFF_FFFF, 16'd65535, 16'd65535, 10'd256,  1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] tune_word;
    logic [15:0] backoff;
    logic [15:0] q_gain;
    logic [9:0]  q_phase_ofs;
    logic        rot_neg;
    logic [11:0] i_samp;
    logic [11:0] q_samp;
    logic        samp_valid;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qtone_gen i_qtone_gen (
        .clk         (clk),
        .rst         (rst),
        .tune_word   (tune_word),
        .backoff     (backoff),
        .q_gain      (q_gain),
        .q_phase_ofs (q_phase_ofs),
        .rot_neg     (rot_neg),
        .i_samp      (i_samp),
        .q_samp      (q_samp),
        .samp_valid  (samp_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int tbl [QTR_N];
    int last_i;
    int last_q;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic near(input string req, input int act, input int exp);
        int d;
        d = act - exp;
        if (d < 0) d = -d;
        chk(d <= TOL, req, act, exp);
    endtask

    function automatic int sine_m(input int a);
        int q;
        int j;
        int v;
        q = (a >> 8) & 3;
        j = a & 255;
        v = tbl[(q & 1) ? (255 - j) : j];
        return (q & 2) ? -v : v;
    endfunction

    function automatic int sat(input int v);
        if (v < 0)    return 0;
        if (v > 4095) return 4095;
        return v;
    endfunction

    function automatic int exp_i(input int ph, input int bo);
        int s;
        int m;
        s = sine_m((ph + 256) & 1023);
        m = ((s < 0 ? -s : s) * bo) >>> 15;
        return sat(s < 0 ? 2048 - m : 2048 + m);
    endfunction

    function automatic int exp_q(input int ph, input int bo, input int gn,
                                 input int ofs, input bit dir);
        int s;
        int m;
        s = sine_m((ph + ofs) & 1023);
        if (dir) s = -s;
        m = ((s < 0 ? -s : s) * bo) >>> 15;
        m = (m * gn) >>> 15;
        return sat(s < 0 ? 2048 - m : 2048 + m);
    endfunction

    task automatic set_cfg(input logic [31:0] tw, input int bo, input int gn,
                           input int ofs, input bit dir);
        tune_word   = tw;
        backoff     = 16'(bo);
        q_gain      = 16'(gn);
        q_phase_ofs = 10'(ofs);
        rot_neg     = dir;
    endtask

    // R1: reset held 3 clocks, midscale and no strobe during it
    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(samp_valid == 1'b0, "R1 valid in reset", int'(samp_valid), 0);
        chk(i_samp == 12'd2048, "R1 I in reset", int'(i_samp), 2048);
        chk(q_samp == 12'd2048, "R1 Q in reset", int'(q_samp), 2048);
        rst = 1'b0;
        last_i = 2048;
        last_q = 2048;
    endtask

    // waits for next strobe, checks R11 hold on idle cycles
    task automatic next_pair(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            if (!samp_valid) begin
                chk(int'(i_samp) == last_i && int'(q_samp) == last_q,
                    "R11 hold", int'(i_samp), last_i);
            end
        end while (!samp_valid);
        last_i = int'(i_samp);
        last_q = int'(q_samp);
    endtask

    task automatic first_pair(input logic [31:0] tw, input int bo, input int gn,
                              input int ofs, input bit dir);
        int gap;
        set_cfg(tw, bo, gn, ofs, dir);
        do_reset();
        next_pair(gap);
    endtask

    initial begin
        int gap;
        for (int j = 0; j < QTR_N; j++) begin
            tbl[j] = $rtoi(2047.0 * $sin((2.0 * j + 1.0) * 3.14159265358979 / 1024.0) + 0.5);
        end
        rst = 1'b1;
        set_cfg(32'd0, 32768, 32768, 0, 1'b0);
        do_reset();

        // vector walk: R3 phase sequence, R4/R5/R6/R7/R8/R9 values, R2 spacing
        for (int v = 0; v < NV; v++) begin
            logic [31:0] tw;
            logic [31:0] acc;
            int bo;
            int gn;
            int ofs;
            bit dir;
            tw  = VECS[v][74:43];
            bo  = int'(VECS[v][42:27]);
            gn  = int'(VECS[v][26:11]);
            ofs = int'(VECS[v][10:1]);
            dir = VECS[v][0];
            set_cfg(tw, bo, gn, ofs, dir);
            do_reset();
            acc = 32'd0;
            for (int k = 0; k < NS; k++) begin
                int ph;
                next_pair(gap);
                if (k > 0) chk(gap == 2, "R2 strobe every second clock", gap, 2);
                ph = int'(acc[31:22]);
                near("R3 R4 R7 R9 I sample", int'(i_samp), exp_i(ph, bo));
                near("R3 R5 R6 R8 R9 Q sample", int'(q_samp), exp_q(ph, bo, gn, ofs, dir));
                acc = acc + tw;
            end
        end

        // directed: frozen phase 0
        first_pair(32'd0, 32768, 32768, 0, 1'b0);
        chk(i_samp == 12'd4095, "R4 I cosine peak", int'(i_samp), 4095);
        chk(q_samp == 12'd2054, "R10 Q S(0)=+6", int'(q_samp), 2054);

        first_pair(32'd0, 32768, 32768, 512, 1'b0);
        chk(q_samp == 12'd2042, "R10 half-cycle mirror", int'(q_samp), 2042);

        first_pair(32'd0, 32768, 32768, 768, 1'b0);
        chk(q_samp == 12'd1, "R5 Q negative peak", int'(q_samp), 1);

        first_pair(32'd0, 65535, 65535, 768, 1'b0);
        chk(i_samp == 12'd4095, "R9 I high rail", int'(i_samp), 4095);
        chk(q_samp == 12'd0, "R9 Q low rail", int'(q_samp), 0);

        first_pair(32'd0, 65535, 65535, 768, 1'b1);
        chk(q_samp == 12'd4095, "R6 Q sign inverted", int'(q_samp), 4095);
        chk(i_samp == 12'd4095, "R6 I unaffected", int'(i_samp), 4095);

        first_pair(32'd0, 0, 32768, 256, 1'b0);
        chk(i_samp == 12'd2048, "R7 zero backoff I", int'(i_samp), 2048);
        chk(q_samp == 12'd2048, "R7 zero backoff Q", int'(q_samp), 2048);

        first_pair(32'd0, 16384, 32768, 0, 1'b0);
        chk(i_samp == 12'd3071, "R7 half backoff I", int'(i_samp), 3071);
        chk(q_samp == 12'd2051, "R7 half backoff Q", int'(q_samp), 2051);

        first_pair(32'd0, 16384, 0, 256, 1'b0);
        chk(q_samp == 12'd2048, "R8 zero gain Q", int'(q_samp), 2048);
        chk(i_samp == 12'd3071, "R8 gain ignored on I", int'(i_samp), 3071);

        first_pair(32'd0, 32768, 16384, 256, 1'b0);
        chk(q_samp == 12'd3071, "R8 half gain Q", int'(q_samp), 3071);

        // R1 restart: second pair after reset advances from phase 0
        first_pair(32'h4000_0000, 32768, 32768, 0, 1'b0);
        chk(i_samp == 12'd4095, "R1 restart phase 0 I", int'(i_samp), 4095);
        next_pair(gap);
        chk(gap == 2, "R2 spacing after restart", gap, 2);
        chk(q_samp == 12'd4095, "R3 quarter step Q", int'(q_samp), 4095);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule